// File: doc/BRIEF.md
# Per-CPU Masked Device Interrupt Router

The router gathers level-sensitive device interrupt lines into one shared raw request vector. Each of several CPUs has its own mask over that vector. A CPU's hard-interrupt output is high whenever at least one raw request is also enabled in that CPU's mask. All CPUs see the same raw requests, but each one filters them independently.

Device lines reach the raw vector in three ways:
- as single events that carry a line index and a new level;
- as a whole level vector that replaces the raw state;
- through a dedicated legacy cascade input, which is wired to raw line 55.

A CSR port gives software the following access:
- read the raw vector;
- read and write each CPU mask;
- read each CPU's masked view.

The raw vector and the masked views are read-only from this port. A presence vector marks which CPUs exist. The outputs of absent CPUs are held low.

Top module: `irq_router`

## Requirements
- R1: A line event (`line_ev_i`) writes `line_lvl_i` into raw bit `line_idx_i`. Level 1 sets the bit and level 0 clears it.
- R2: `level_load_i` replaces the whole raw vector with `level_vec_i`. A line event in the same cycle is applied on top of the loaded vector.
- R3: Each `irq_o[n]` is registered. One cycle after any raw change, mask write or presence change, it equals `cpu_present_i[n] AND |(mask n & raw)`.
- R4: The mask for CPU n is read and written at byte offset 0x200 + 0x40*n for n = 0, 1, and at 0x600 + 0x40*(n-2) for n = 2, 3. A write takes effect at the next clock edge.
- R5: The masked view of CPU n sits at its mask offset + 0x80 (0x280, 0x2C0, 0x680, 0x6C0) and reads as mask n AND raw. Writes to a view change no state.
- R6: The raw vector reads at offset 0x300. Writes to 0x300 change no state.
- R7: A change of `cascade_i` writes its new level into raw bit 55. This takes priority over a same-cycle level load or line event on bit 55. While `cascade_i` is steady, it has no effect.
- R8: While `cpu_present_i[n]` is 0, `irq_o[n]` is 0 one cycle later, whatever the mask and raw state.
- R9: Reads of unmapped offsets (and any read while `csr_req_i` is low) return 0. Writes to unmapped offsets change no state.
- R10: After reset, the raw vector, all masks and all `irq_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_present_i | input | NUM_CPUS | One bit per CPU that exists |
| line_ev_i | input | 1 | Single-line level event valid |
| line_idx_i | input | IDX_W | Line index of the event |
| line_lvl_i | input | 1 | New level of the indexed line |
| level_load_i | input | 1 | Load the whole raw vector |
| level_vec_i | input | NUM_LINES | Level vector for the load |
| cascade_i | input | 1 | Legacy cascade interrupt level (raw line 55) |
| csr_req_i | input | 1 | CSR access valid |
| csr_we_i | input | 1 | CSR write (1) or read (0) |
| csr_addr_i | input | 12 | CSR byte offset |
| csr_wdata_i | input | NUM_LINES | CSR write data |
| csr_rdata_o | output | NUM_LINES | CSR read data (combinational) |
| irq_o | output | NUM_CPUS | Per-CPU hard-interrupt request |

## Verification
The bench walks every raw line through a set and a clear, with a different mask pattern on each CPU. This exposes a router that ORs the lines instead of ANDing them with the mask, or that shares one mask across CPUs. It also exposes an output that lags by more than one cycle or updates in the same cycle.

It drives a level load, a line event and a cascade edge together on one line. A wrong priority order would leave the wrong level in raw bit 55 or in the evented bit.

It writes all ones to the raw offset, to a view offset and to an unmapped offset, then reads the raw vector and every mask back. A decoder that aliases these offsets onto a mask would show up as a corrupted readback.

Finally, it withdraws CPUs from the presence vector while their requests are pending. An output that ignores presence would stay high.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int unsigned CSR_AW = 12;
  localparam logic [CSR_AW-1:0] RAW_OFS = 12'h300;

  function automatic logic [CSR_AW-1:0] mask_ofs(int unsigned n);
    int unsigned v;
    v = (n < 2) ? (32'h200 + 32'h40 * n) : (32'h600 + 32'h40 * (n - 2));
    return v[CSR_AW-1:0];
  endfunction

  function automatic logic [CSR_AW-1:0] view_ofs(int unsigned n);
    return mask_ofs(n) + 12'h080;
  endfunction
endpackage

// File: rtl/irq_raw_collect.sv
module irq_raw_collect #(
  parameter int unsigned NUM_LINES    = 64,
  parameter int unsigned CASCADE_LINE = 55,
  localparam int unsigned IDX_W       = $clog2(NUM_LINES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 line_ev_i,
  input  logic [IDX_W-1:0]     line_idx_i,
  input  logic                 line_lvl_i,
  input  logic                 level_load_i,
  input  logic [NUM_LINES-1:0] level_vec_i,
  input  logic                 cascade_i,
  output logic [NUM_LINES-1:0] raw_d_o,
  output logic [NUM_LINES-1:0] raw_q_o,
  output logic                 casc_q_o
);
  logic [NUM_LINES-1:0] raw_q;
  logic                 casc_q;

  // priority: vector load < line event < cascade edge
  always_comb begin
    raw_d_o = raw_q;
    if (level_load_i) raw_d_o = level_vec_i;
    if (line_ev_i) raw_d_o[line_idx_i] = line_lvl_i;
    if (cascade_i != casc_q) raw_d_o[CASCADE_LINE] = cascade_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q  <= '0;
      casc_q <= 1'b0;
    end else begin
      raw_q  <= raw_d_o;
      casc_q <= cascade_i;
    end
  end

  assign raw_q_o  = raw_q;
  assign casc_q_o = casc_q;
endmodule

// File: rtl/irq_mask_csr.sv
module irq_mask_csr
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_LINES = 64,
  parameter int unsigned NUM_CPUS  = 4
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                csr_req_i,
  input  logic                                csr_we_i,
  input  logic [CSR_AW-1:0]                   csr_addr_i,
  input  logic [NUM_LINES-1:0]                csr_wdata_i,
  input  logic [NUM_LINES-1:0]                raw_q_i,
  output logic [NUM_CPUS-1:0][NUM_LINES-1:0]  mask_d_o,
  output logic [NUM_CPUS-1:0][NUM_LINES-1:0]  mask_q_o,
  output logic [NUM_LINES-1:0]                csr_rdata_o
);
  logic csr_wr;
  assign csr_wr = csr_req_i && csr_we_i;

  for (genvar n = 0; n < NUM_CPUS; n++) begin : g_mask
    logic [NUM_LINES-1:0] mask_q;
    assign mask_d_o[n] = (csr_wr && csr_addr_i == mask_ofs(n)) ? csr_wdata_i : mask_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mask_q <= '0;
      else         mask_q <= mask_d_o[n];
    end
    assign mask_q_o[n] = mask_q;
  end

  always_comb begin
    csr_rdata_o = '0;
    if (csr_req_i && !csr_we_i) begin
      if (csr_addr_i == RAW_OFS) csr_rdata_o = raw_q_i;
      for (int n = 0; n < NUM_CPUS; n++) begin
        if (csr_addr_i == mask_ofs(n)) csr_rdata_o = mask_q_o[n];
        if (csr_addr_i == view_ofs(n)) csr_rdata_o = mask_q_o[n] & raw_q_i;
      end
    end
  end
endmodule

// File: rtl/irq_cpu_gate.sv
module irq_cpu_gate #(
  parameter int unsigned NUM_LINES = 64
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] mask_d_i,
  input  logic [NUM_LINES-1:0] raw_d_i,
  input  logic                 present_i,
  output logic                 irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= present_i && (|(mask_d_i & raw_d_i));
  end
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_LINES    = 64,
  parameter int unsigned NUM_CPUS     = 4,
  parameter int unsigned CASCADE_LINE = 55,
  localparam int unsigned IDX_W       = $clog2(NUM_LINES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_CPUS-1:0]  cpu_present_i,
  input  logic                 line_ev_i,
  input  logic [IDX_W-1:0]     line_idx_i,
  input  logic                 line_lvl_i,
  input  logic                 level_load_i,
  input  logic [NUM_LINES-1:0] level_vec_i,
  input  logic                 cascade_i,
  input  logic                 csr_req_i,
  input  logic                 csr_we_i,
  input  logic [CSR_AW-1:0]    csr_addr_i,
  input  logic [NUM_LINES-1:0] csr_wdata_i,
  output logic [NUM_LINES-1:0] csr_rdata_o,
  output logic [NUM_CPUS-1:0]  irq_o
);
  logic [NUM_LINES-1:0]               raw_d, raw_q;
  logic                               casc_q;
  logic [NUM_CPUS-1:0][NUM_LINES-1:0] mask_d, mask_q;

  irq_raw_collect #(.NUM_LINES(NUM_LINES), .CASCADE_LINE(CASCADE_LINE)) u_raw (
    .clk_i, .rst_ni, .line_ev_i, .line_idx_i, .line_lvl_i,
    .level_load_i, .level_vec_i, .cascade_i,
    .raw_d_o(raw_d), .raw_q_o(raw_q), .casc_q_o(casc_q)
  );

  irq_mask_csr #(.NUM_LINES(NUM_LINES), .NUM_CPUS(NUM_CPUS)) u_csr (
    .clk_i, .rst_ni, .csr_req_i, .csr_we_i, .csr_addr_i, .csr_wdata_i,
    .raw_q_i(raw_q), .mask_d_o(mask_d), .mask_q_o(mask_q), .csr_rdata_o
  );

  for (genvar n = 0; n < NUM_CPUS; n++) begin : g_cpu
    irq_cpu_gate #(.NUM_LINES(NUM_LINES)) u_gate (
      .clk_i, .rst_ni,
      .mask_d_i(mask_d[n]), .raw_d_i(raw_d),
      .present_i(cpu_present_i[n]), .irq_o(irq_o[n])
    );
  end
endmodule

// File: rtl/irq_router_sva.sv
module irq_router_sva
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_LINES    = 64,
  parameter int unsigned NUM_CPUS     = 4,
  parameter int unsigned CASCADE_LINE = 55,
  localparam int unsigned IDX_W       = $clog2(NUM_LINES)
) (
  input logic                               clk_i,
  input logic                               rst_ni,
  input logic [NUM_CPUS-1:0]                cpu_present_i,
  input logic                               line_ev_i,
  input logic [IDX_W-1:0]                   line_idx_i,
  input logic                               line_lvl_i,
  input logic                               level_load_i,
  input logic                               cascade_i,
  input logic                               csr_req_i,
  input logic                               csr_we_i,
  input logic [CSR_AW-1:0]                  csr_addr_i,
  input logic [NUM_LINES-1:0]               csr_wdata_i,
  input logic [NUM_CPUS-1:0]                irq_o,
  input logic [NUM_LINES-1:0]               raw_q,
  input logic [NUM_CPUS-1:0][NUM_LINES-1:0] mask_q,
  input logic                               casc_q
);
  logic casc_hit;
  assign casc_hit = (line_idx_i == IDX_W'(CASCADE_LINE)) && (cascade_i != casc_q);

  a_r1_event_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_ev_i && line_lvl_i && !casc_hit |=> raw_q[$past(line_idx_i)]);

  a_r1_event_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_ev_i && !line_lvl_i && !casc_hit |=> !raw_q[$past(line_idx_i)]);

  a_r7_cascade_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cascade_i && !casc_q |=> raw_q[CASCADE_LINE]);

  a_r6_raw_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_req_i && csr_we_i && csr_addr_i == RAW_OFS && !line_ev_i && !level_load_i
    && cascade_i == casc_q |=> $stable(raw_q));

  for (genvar n = 0; n < NUM_CPUS; n++) begin : g_cpu
    a_r4_mask_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
      csr_req_i && csr_we_i && csr_addr_i == mask_ofs(n) |=> mask_q[n] == $past(csr_wdata_i));

    a_r3_irq_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> irq_o[n] == ($past(cpu_present_i[n]) && (|(mask_q[n] & raw_q))));

    a_r8_absent_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cpu_present_i[n] |=> !irq_o[n]);
  end
endmodule

bind irq_router irq_router_sva #(
  .NUM_LINES(NUM_LINES), .NUM_CPUS(NUM_CPUS), .CASCADE_LINE(CASCADE_LINE)
) u_sva (.*);

// File: tb/irq_router_test.sv
module irq_router_test;
  localparam int NL = 64;
  localparam int NC = 4;
  localparam int CL = 55;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NC-1:0] cpu_present_i = '1;
  logic          line_ev_i = 1'b0;
  logic [5:0]    line_idx_i = '0;
  logic          line_lvl_i = 1'b0;
  logic          level_load_i = 1'b0;
  logic [NL-1:0] level_vec_i = '0;
  logic          cascade_i = 1'b0;
  logic          csr_req_i = 1'b0;
  logic          csr_we_i = 1'b0;
  logic [11:0]   csr_addr_i = '0;
  logic [NL-1:0] csr_wdata_i = '0;
  logic [NL-1:0] csr_rdata_o;
  logic [NC-1:0] irq_o;

  irq_router uut (.*);

  always #2 clk_i = ~clk_i;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [NL-1:0] raw_m = '0;
  logic [NL-1:0] mask_m [NC];
  logic          casc_m = 1'b0;

  function automatic logic [11:0] m_ofs(int n);
    return (n < 2) ? 12'(32'h200 + 32'h40 * n) : 12'(32'h600 + 32'h40 * (n - 2));
  endfunction

  task automatic chk(string req, logic [NL-1:0] act, logic [NL-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(logic [11:0] a, output logic [NL-1:0] d);
    csr_req_i = 1; csr_we_i = 0; csr_addr_i = a;
    #1 d = csr_rdata_o;
    csr_req_i = 0;
  endtask

  task automatic check_irq(string req);
    logic [NC-1:0] e;
    for (int n = 0; n < NC; n++) e[n] = cpu_present_i[n] && (|(mask_m[n] & raw_m));
    chk(req, NL'(irq_o), NL'(e));
  endtask

  task automatic check_regs(string req);
    logic [NL-1:0] d;
    rd(12'h300, d); chk({req, " raw"}, d, raw_m);
    for (int n = 0; n < NC; n++) begin
      rd(m_ofs(n) + 12'h080, d); chk({req, " view"}, d, mask_m[n] & raw_m);
    end
  endtask

  // drive line inputs for one edge, then update the model
  task automatic cyc(logic ld, logic [NL-1:0] vec, logic ev, int idx, logic lvl, logic casc);
    logic [NL-1:0] t;
    level_load_i = ld; level_vec_i = vec; line_ev_i = ev;
    line_idx_i = 6'(idx); line_lvl_i = lvl; cascade_i = casc;
    @(posedge clk_i); #1;
    level_load_i = 0; line_ev_i = 0;
    t = raw_m;
    if (ld) t = vec;
    if (ev) t[idx] = lvl;
    if (casc != casc_m) t[CL] = casc;
    casc_m = casc;
    raw_m = t;
  endtask

  task automatic wr(logic [11:0] a, logic [NL-1:0] d);
    csr_req_i = 1; csr_we_i = 1; csr_addr_i = a; csr_wdata_i = d;
    @(posedge clk_i); #1;
    csr_req_i = 0; csr_we_i = 0;
    for (int n = 0; n < NC; n++) if (a == m_ofs(n)) mask_m[n] = d;
  endtask

  task automatic idle();
    @(posedge clk_i); #1;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [NL-1:0] d;
    for (int n = 0; n < NC; n++) mask_m[n] = '0;
    #7 rst_ni = 1;
    @(posedge clk_i); #1;

    // R10 reset state
    chk("R10 irq", NL'(irq_o), '0);
    rd(12'h300, d); chk("R10 raw", d, '0);
    for (int n = 0; n < NC; n++) begin
      rd(m_ofs(n), d); chk("R10 mask", d, '0);
    end

    // R4 masks: distinct pattern per CPU; irq follows one cycle later (R3)
    wr(m_ofs(0), '1);
    wr(m_ofs(1), {32{2'b01}});
    wr(m_ofs(2), {32{2'b10}});
    wr(m_ofs(3), NL'(1) << CL);
    for (int n = 0; n < NC; n++) begin
      rd(m_ofs(n), d); chk("R4 mask readback", d, mask_m[n]);
    end

    // R1/R3/R5/R6 sweep every line through set and clear
    for (int i = 0; i < NL; i++) begin
      cyc(0, '0, 1, i, 1, casc_m);
      check_irq("R3 set sweep"); check_regs("R1 set sweep");
      cyc(0, '0, 1, i, 0, casc_m);
      check_irq("R3 clr sweep"); check_regs("R1 clr sweep");
    end

    // R2 vector loads
    cyc(1, {32{2'b10}}, 0, 0, 0, casc_m); check_irq("R2 load odd"); check_regs("R2 load odd");
    cyc(1, NL'(1) << 63, 0, 0, 0, casc_m); check_irq("R2 load top"); check_regs("R2 load top");
    cyc(1, '1, 0, 0, 0, casc_m); check_irq("R2 load ones"); check_regs("R2 load ones");
    cyc(1, '0, 1, 10, 1, casc_m); check_irq("R2 load+event"); check_regs("R2 load+event");
    cyc(1, '1, 1, 20, 0, casc_m); check_regs("R2 load+event clr");

    // R7 cascade
    cyc(1, '0, 0, 0, 0, casc_m); check_regs("R7 clear");
    cyc(0, '0, 0, 0, 0, 1); check_irq("R7 cascade rise"); check_regs("R7 cascade rise");
    cyc(0, '0, 1, CL, 0, 1); check_regs("R7 steady cascade no effect");
    cyc(0, '0, 0, 0, 0, 0); check_regs("R7 cascade fall");
    cyc(1, '0, 1, CL, 0, 1); check_irq("R7 priority over load/event"); check_regs("R7 priority");
    cyc(1, '1, 0, 0, 0, 0); check_regs("R7 fall beats load");

    // R5/R6/R9 writes ignored
    cyc(1, {16{4'h5}}, 0, 0, 0, casc_m);
    wr(12'h300, '1);
    rd(12'h300, d); chk("R6 raw write ignored", d, raw_m);
    for (int n = 0; n < NC; n++) begin
      wr(m_ofs(n) + 12'h080, '1);
      rd(m_ofs(n), d); chk("R5 view write ignored", d, mask_m[n]);
    end
    check_regs("R5 views after writes");
    wr(12'h380, '1); wr(12'h000, '1);
    for (int n = 0; n < NC; n++) begin
      rd(m_ofs(n), d); chk("R9 unmapped write ignored", d, mask_m[n]);
    end
    rd(12'h380, d); chk("R9 unmapped read", d, '0);
    csr_req_i = 0; csr_addr_i = 12'h300; #1 chk("R9 no req read", csr_rdata_o, '0);

    // R3 mask write drives irq next cycle
    cyc(1, NL'(1) << 3, 0, 0, 0, casc_m);
    wr(m_ofs(3), NL'(1) << 3); check_irq("R3 mask write on");
    wr(m_ofs(3), '0); check_irq("R3 mask write off");

    // R8 absence
    for (int n = 0; n < NC; n++) mask_m[n] = '1;
    for (int n = 0; n < NC; n++) wr(m_ofs(n), '1);
    cyc(1, '1, 0, 0, 0, casc_m);
    for (int p = 0; p < 16; p++) begin
      cpu_present_i = 4'(p);
      idle(); check_irq("R8 presence");
    end
    cpu_present_i = '1;
    idle(); check_irq("R8 restore");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule